// File: doc/BRIEF.md
# DMA Channel Activation Controller

This block governs the run state of a single data-mover channel. Software issues command pulses through a small activation vector with four bits: start, stop, pause and restart. The controller tracks whether the channel is idle, active or paused, and accepts a command only when it is legal in the current state. It ignores any other command and latches an error flag that stays set. A completion pulse from the datapath ends an active transfer and returns the channel to idle.

The block also holds the channel configuration word. That word carries an operation-mode field, an access-protect bit and two burst-limit codes, one for reads and one for writes. Ordinary configuration writes never disturb the operation mode. The mode has its own write path, and that path is refused while the channel is running, so a transfer cannot change personality in the middle.

Top module: `dma_chan_ctrl`

## Requirements
- R1: `status` encodes idle as 2'b00, active as 2'b01 and paused as 2'b10, and never shows 2'b11. After reset, status is idle and `cmd_err` is 0.
- R2: A lone start bit (`cmd` = 4'b0001) in the idle or paused state makes status active on the next clock.
- R3: A lone pause bit (`cmd` = 4'b0100) in the active state makes status paused on the next clock.
- R4: A lone restart bit (`cmd` = 4'b1000) in the paused state makes status active on the next clock.
- R5: A lone stop bit (`cmd` = 4'b0010) in the active state makes status idle on the next clock. A stop in the idle state changes nothing and raises no error.
- R6: A lone command bit that is not legal in the current state leaves status unchanged and sets `cmd_err` on the next clock. The illegal cases are start while active, pause while idle or paused, restart while idle or active, and stop while paused.
- R7: A `cmd` value with more than one bit set is ignored and sets `cmd_err`.
- R8: Once set, `cmd_err` stays set until reset.
- R9: `xfer_done` in the active state makes status idle on the next clock. A command in the same cycle is dropped without raising an error. `xfer_done` in any other state is ignored.
- R10: The `cfg_q` layout is as follows: bits [2:0] hold the mode, bit [3] holds the protect bit, bits [6:4] hold the read burst code and bits [9:7] hold the write burst code. The reset value is 10'h248 (mode 0, protect 1, both burst codes 4).
- R11: `cfg_we` loads bits [9:3] from `cfg_wdata` and keeps the mode bits [2:0].
- R12: `mode_we` loads the mode bits from `mode_wdata` when status is not active. While status is active, it has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd | input | 4 | Command pulses, one cycle each: bit0 start, bit1 stop, bit2 pause, bit3 restart |
| xfer_done | input | 1 | Datapath completion pulse |
| cfg_we | input | 1 | Configuration write strobe (mode bits excluded) |
| cfg_wdata | input | 10 | Configuration write data |
| mode_we | input | 1 | Operation-mode write strobe |
| mode_wdata | input | 3 | Operation-mode write data |
| status | output | 2 | Channel state |
| cmd_err | output | 1 | Sticky flag for an illegal or multi-bit command |
| cfg_q | output | 10 | Current configuration word |

## Verification
The properties assume that `cmd` bits and `xfer_done` are single-cycle pulses sampled on the rising edge. They also assume that `xfer_done` comes only from a datapath that may finish at any time, even in the same cycle as a command. The stimulus drives every input on the falling edge and clears command bits one cycle later, so each command is seen exactly once. Done pulses are also issued in idle and together with a pause, which checks the priority rule and the rule that a stray done is ignored. The stimulus never raises `mode_we` and `cfg_we` together, so the property about mode retention covers only a configuration write on its own.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'b00,
        ST_ACTIVE = 2'b01,
        ST_PAUSED = 2'b10
    } chan_st_e;

    localparam int NCMD        = 4;
    localparam int CMD_START   = 0;
    localparam int CMD_STOP    = 1;
    localparam int CMD_PAUSE   = 2;
    localparam int CMD_RESTART = 3;

endpackage

// File: rtl/dma_chan_cmd_chk.sv
module dma_chan_cmd_chk
    import dma_chan_pkg::*;
(
    input  logic [NCMD-1:0] cmd,
    input  chan_st_e        st,
    output logic            to_active,
    output logic            to_paused,
    output logic            to_idle,
    output logic            illegal
);

    logic multi;
    logic single;

    always_comb begin
        multi     = (cmd & (cmd - NCMD'(1))) != '0;
        single    = (cmd != '0) && !multi;
        to_active = 1'b0;
        to_paused = 1'b0;
        to_idle   = 1'b0;
        illegal   = multi;
        if (single) begin
            unique case (1'b1)
                cmd[CMD_START]: begin
                    if (st == ST_IDLE || st == ST_PAUSED) to_active = 1'b1;
                    else                                   illegal   = 1'b1;
                end
                cmd[CMD_STOP]: begin
                    // stop while idle is a harmless no-op
                    if (st == ST_ACTIVE)    to_idle = 1'b1;
                    else if (st != ST_IDLE) illegal = 1'b1;
                end
                cmd[CMD_PAUSE]: begin
                    if (st == ST_ACTIVE) to_paused = 1'b1;
                    else                 illegal   = 1'b1;
                end
                cmd[CMD_RESTART]: begin
                    if (st == ST_PAUSED) to_active = 1'b1;
                    else                 illegal   = 1'b1;
                end
                default: illegal = 1'b1;
            endcase
        end
    end

endmodule

// File: rtl/dma_chan_cfg.sv
module dma_chan_cfg #(
    parameter int MODE_W    = 3,
    parameter int BURST_W   = 3,
    parameter int BURST_RST = 4,
    localparam int CFG_W    = 2*BURST_W + 1 + MODE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CFG_W-1:0]  cfg_wdata,
    input  logic              mode_we,
    input  logic [MODE_W-1:0] mode_wdata,
    input  logic              chan_busy,
    output logic [CFG_W-1:0]  cfg_o
);

    localparam logic [CFG_W-1:0] CFG_RST =
        {BURST_W'(BURST_RST), BURST_W'(BURST_RST), 1'b1, {MODE_W{1'b0}}};

    logic [CFG_W-1:0] cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (cfg_we)
            cfg_d[CFG_W-1:MODE_W] = cfg_wdata[CFG_W-1:MODE_W];
        if (mode_we && !chan_busy)
            cfg_d[MODE_W-1:0] = mode_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= CFG_RST;
        else        cfg_q <= cfg_d;
    end

    assign cfg_o = cfg_q;

    assert_cfg_keeps_mode_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !mode_we) |=> ($stable(cfg_q[MODE_W-1:0]) &&
            cfg_q[CFG_W-1:MODE_W] == $past(cfg_wdata[CFG_W-1:MODE_W])));

    assert_mode_locked_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_we && chan_busy) |=> $stable(cfg_q[MODE_W-1:0]));

    assert_mode_load_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_we && !chan_busy) |=> cfg_q[MODE_W-1:0] == $past(mode_wdata));

endmodule

// File: rtl/dma_chan_ctrl.sv
module dma_chan_ctrl
    import dma_chan_pkg::*;
#(
    parameter int MODE_W    = 3,
    parameter int BURST_W   = 3,
    parameter int BURST_RST = 4,
    localparam int CFG_W    = 2*BURST_W + 1 + MODE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NCMD-1:0]   cmd,
    input  logic              xfer_done,
    input  logic              cfg_we,
    input  logic [CFG_W-1:0]  cfg_wdata,
    input  logic              mode_we,
    input  logic [MODE_W-1:0] mode_wdata,
    output logic [1:0]        status,
    output logic              cmd_err,
    output logic [CFG_W-1:0]  cfg_q
);

    typedef struct packed {
        chan_st_e st;
        logic     err;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;
    logic  to_active, to_paused, to_idle, illegal;
    logic  finish;

    dma_chan_cmd_chk u_chk (
        .cmd       (cmd),
        .st        (ctrl_q.st),
        .to_active (to_active),
        .to_paused (to_paused),
        .to_idle   (to_idle),
        .illegal   (illegal)
    );

    dma_chan_cfg #(
        .MODE_W    (MODE_W),
        .BURST_W   (BURST_W),
        .BURST_RST (BURST_RST)
    ) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_wdata  (cfg_wdata),
        .mode_we    (mode_we),
        .mode_wdata (mode_wdata),
        .chan_busy  (ctrl_q.st == ST_ACTIVE),
        .cfg_o      (cfg_q)
    );

    assign finish = xfer_done && (ctrl_q.st == ST_ACTIVE);

    always_comb begin
        ctrl_d = ctrl_q;
        if (finish) begin
            // completion wins; a same-cycle command is dropped unflagged
            ctrl_d.st = ST_IDLE;
        end else begin
            if (to_active)      ctrl_d.st = ST_ACTIVE;
            else if (to_paused) ctrl_d.st = ST_PAUSED;
            else if (to_idle)   ctrl_d.st = ST_IDLE;
            if (illegal)        ctrl_d.err = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q <= '{st: ST_IDLE, err: 1'b0};
        else        ctrl_q <= ctrl_d;
    end

    assign status  = ctrl_q.st;
    assign cmd_err = ctrl_q.err;

    assert_status_code_R1: assert property (@(posedge clk) disable iff (!rst_n)
        status != 2'b11);

    assert_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == 4'b0001 && !xfer_done && status != 2'b01) |=> status == 2'b01);

    assert_pause_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == 4'b0100 && !xfer_done && status == 2'b01) |=> status == 2'b10);

    assert_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == 4'b1000 && status == 2'b10) |=> status == 2'b01);

    assert_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == 4'b0010 && !xfer_done && status == 2'b01) |=> status == 2'b00);

    assert_bad_pause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == 4'b0100 && status != 2'b01) |=> (cmd_err && status == $past(status)));

    assert_multi_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(cmd) > 1 && !(xfer_done && status == 2'b01))
        |=> (cmd_err && status == $past(status)));

    assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_err |=> cmd_err);

    assert_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_done && status == 2'b01) |=> status == 2'b00);

endmodule

// File: tb/dma_chan_ctrl_test.sv
module dma_chan_ctrl_test;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] cmd = '0;
    logic       xfer_done = 1'b0;
    logic       cfg_we = 1'b0;
    logic [9:0] cfg_wdata = '0;
    logic       mode_we = 1'b0;
    logic [2:0] mode_wdata = '0;
    logic [1:0] status;
    logic       cmd_err;
    logic [9:0] cfg_q;

    int total = 0;
    int bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_chan_ctrl uut (
        .clk(clk), .rst_n(rst_n), .cmd(cmd), .xfer_done(xfer_done),
        .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .mode_we(mode_we),
        .mode_wdata(mode_wdata), .status(status), .cmd_err(cmd_err), .cfg_q(cfg_q)
    );

    // entry = {cmd[3:0], done, expected status[1:0], expected err}
    localparam logic [7:0] VEC [12] = '{
        8'b0010_0_00_0,  // R5 stop while idle: no change, no error
        8'b0001_0_01_0,  // R2 start from idle
        8'b0100_0_10_0,  // R3 pause
        8'b0001_0_01_0,  // R2 start from paused
        8'b0100_0_10_0,  // R3 pause
        8'b1000_0_01_0,  // R4 restart
        8'b0000_1_00_0,  // R9 done ends transfer
        8'b0001_0_01_0,  // R2 start
        8'b0010_0_00_0,  // R5 stop while active
        8'b0000_1_00_0,  // R9 done while idle ignored
        8'b0001_0_01_0,  // R2 start
        8'b0100_1_00_0   // R9 done beats pause, no error
    };

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic apply(input logic [3:0] c, input logic d);
        @(negedge clk);
        cmd = c;
        xfer_done = d;
        @(negedge clk);
        cmd = '0;
        xfer_done = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        do_reset();
        check("R1 reset status", int'(status), 0);
        check("R1 reset err", int'(cmd_err), 0);
        check("R10 reset cfg", int'(cfg_q), 'h248);

        foreach (VEC[i]) begin
            apply(VEC[i][7:4], VEC[i][3]);
            check($sformatf("vec%0d status", i), int'(status), int'(VEC[i][2:1]));
            check($sformatf("vec%0d err", i), int'(cmd_err), int'(VEC[i][0]));
        end

        // R6 restart while idle is ignored and flagged
        do_reset();
        apply(4'b1000, 1'b0);
        check("R6 restart@idle status", int'(status), 0);
        check("R6 restart@idle err", int'(cmd_err), 1);
        // R8 error survives later legal commands
        apply(4'b0001, 1'b0);
        check("R8 err sticky", int'(cmd_err), 1);
        check("R2 start after err", int'(status), 1);

        // R6 stop while paused is illegal
        do_reset();
        apply(4'b0001, 1'b0);
        apply(4'b0100, 1'b0);
        apply(4'b0010, 1'b0);
        check("R6 stop@paused status", int'(status), 2);
        check("R6 stop@paused err", int'(cmd_err), 1);

        // R6 start while active is illegal
        do_reset();
        apply(4'b0001, 1'b0);
        apply(4'b0001, 1'b0);
        check("R6 start@active status", int'(status), 1);
        check("R6 start@active err", int'(cmd_err), 1);

        // R7 two bits at once
        do_reset();
        apply(4'b0011, 1'b0);
        check("R7 multi status", int'(status), 0);
        check("R7 multi err", int'(cmd_err), 1);

        // R11 config write keeps the mode bits
        do_reset();
        @(negedge clk);
        mode_we = 1'b1; mode_wdata = 3'd2;
        @(negedge clk);
        mode_we = 1'b0;
        check("R12 mode load idle", int'(cfg_q), 'h24A);
        cfg_we = 1'b1; cfg_wdata = 10'h0F5;
        @(negedge clk);
        cfg_we = 1'b0;
        check("R11 cfg keeps mode", int'(cfg_q), (10'h0F5 & ~10'h7) | 10'd2);

        // R12 mode write ignored while active
        apply(4'b0001, 1'b0);
        @(negedge clk);
        mode_we = 1'b1; mode_wdata = 3'd5;
        @(negedge clk);
        mode_we = 1'b0;
        check("R12 mode locked active", int'(cfg_q), 'h0F2);
        apply(4'b0100, 1'b0);
        @(negedge clk);
        mode_we = 1'b1; mode_wdata = 3'd5;
        @(negedge clk);
        mode_we = 1'b0;
        check("R12 mode load paused", int'(cfg_q), 'h0F5);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule